// File: doc/BRIEF.md
# Clock Recovery Frequency Error Trimmer

This block keeps a free-running fast oscillator locked to a slow reference pulse. A 16-bit error counter is loaded from a programmable reload value, counts down to zero, then turns round and counts up. Each reference event captures the count and the direction it was moving in, then reloads the counter. With the reload set to the ratio of target to reference frequency minus one, a correctly tuned oscillator presents a capture of zero. A nonzero capture is graded against an 8-bit limit into OK, warning or error. In automatic mode the grade moves a 7-bit oscillator trim code up or down.

The reference can come from one of three raw inputs. It passes through an edge selector and a power-of-two prescaler. A software sync bit in the control register can also make an event on its own. Software configures the block through a small synchronous register port. Status flags are sticky and cleared by writing ones. The enabled flags are ORed into a single interrupt line.

Top module: `crt_trimmer`

## Requirements
- R1: After reset the control register reads 0x00004000 (trim 64, everything off), the config register reads 0x2022BB7F (reload 0xBB7F, limit 0x22, divider code 0, source 2, rising edge), status reads 0, trim_o is 64 and irq_o is low.
- R2: Register map. Address 0 is control: bits 3:0 are the interrupt enables for OK, warning, error and expected-sync; bit 5 is counter enable; bit 6 is automatic trim; bit 7 is the write-only software sync; bits 14:8 are trim. Address 1 is config: bits 15:0 reload, bits 23:16 limit, bits 26:24 divider code, bits 29:28 source, bit 31 polarity. Address 2 is status: bit 0 OK, bit 1 warning, bit 2 combined error, bit 3 expected-sync, bit 8 sync error, bit 9 sync missed, bit 10 trim overflow, bit 15 direction, bits 31:16 capture. Address 3 is the clear register. While the counter is disabled it holds the reload value. The clock edge that enables it acts as the first sync. If the next sync comes P clocks later, the capture is |P - (reload+1)|, and the direction bit is 1 only when P > reload+1.
- R3: A capture below the limit sets OK. A capture from the limit up to, but not including, three times the limit sets warning. A capture of three times the limit or more sets sync error.
- R4: Expected-sync sets at a clock edge where the enabled counter is counting down and holds zero, even if a sync lands on the same edge.
- R5: In the up direction with no sync, a count above three times the limit sets sync missed. The counter then freezes and the trim is left alone. The next sync reloads the counter and captures the count without grading it.
- R6: In automatic mode the trim moves by 1 on a nonzero OK capture and by 2 on a warning capture. It moves down when direction is 0 and up when direction is 1. It is unchanged on sync error or a zero capture, and never changes in manual mode.
- R7: The trim saturates at 0 and 127. A step that would leave that range sets trim overflow.
- R8: A control write updates trim only if automatic mode was off before that write.
- R9: While counter enable is set, config writes have no effect.
- R10: The sync source is chosen by the source field. Polarity 0 uses rising edges and 1 uses falling edges. Divider code d passes one of every 2^d selected edges, and the prescaler restarts whenever counting is disabled.
- R11: Writing control with bit 7 set makes one sync event while counting is enabled, whatever the raw inputs do.
- R12: Flags stay set until cleared by writing a one to the clear register. Clear bit 0 clears OK, bit 1 clears warning, bit 3 clears expected-sync, and bit 2 clears sync error, sync missed and trim overflow together. The combined error bit is the OR of those three.
- R13: irq_o is high exactly when some flag among OK, warning, combined error and expected-sync is set with its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| sync_in | input | NSRC | Raw reference pulse inputs |
| trim_o | output | 7 | Oscillator trim code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the grading boundaries: captures exactly at the limit and exactly at three times the limit, in both directions. An off-by-one comparison there would report the wrong grade and step the trim the wrong amount. It puts a sync on the very edge where the count sits at zero. A design that counted one clock too many or too few would capture 1 instead of 0 and show no expected-sync. It lets the up-count run away to check that the counter freezes and that the recovery sync is not graded. A design without this would flag a spurious error or move the trim. It also drives the trim into both saturation rails, where wrap-around would show as a jump to the far end of the range. Finally it sends falling edges through the divide-by-4 prescaler while the other inputs toggle. A wrong source, edge or divider setting would turn the event into an early, graded error.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CNT_W  = 16;
  localparam int LIM_W  = 8;
  localparam int TRIM_W = 7;
  localparam int DIV_W  = 3;
  localparam int SEL_W  = 2;
  localparam int L3_W   = LIM_W + 2;

  localparam logic [TRIM_W-1:0] TRIM_MAX   = '1;
  localparam logic [TRIM_W-1:0] TRIM_RST   = 7'd64;
  localparam logic [CNT_W-1:0]  RELOAD_RST = 16'hBB7F;
  localparam logic [LIM_W-1:0]  LIMIT_RST  = 8'h22;
  localparam logic [SEL_W-1:0]  SRC_RST    = 2'd2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  localparam int B_EN     = 5;
  localparam int B_AUTO   = 6;
  localparam int B_SWSYNC = 7;
  localparam int B_TRIM   = 8;
  localparam int B_LIM    = 16;
  localparam int B_DIV    = 24;
  localparam int B_SRC    = 28;
  localparam int B_POL    = 31;

  typedef enum logic [1:0] {CLS_OK = 2'd0, CLS_WARN = 2'd1, CLS_ERR = 2'd2} crt_cls_e;

  // three times the limit, widened to the counter
  function automatic logic [CNT_W-1:0] crt_lim3(input logic [LIM_W-1:0] lim);
    logic [L3_W-1:0] t;
    t = {2'b00, lim} + {1'b0, lim, 1'b0};
    return CNT_W'(t);
  endfunction

  function automatic crt_cls_e crt_classify(input logic [CNT_W-1:0] mag,
                                            input logic [LIM_W-1:0] lim);
    if (mag < CNT_W'(lim))     return CLS_OK;
    if (mag < crt_lim3(lim))   return CLS_WARN;
    return CLS_ERR;
  endfunction

  function automatic logic [1:0] crt_step(input crt_cls_e cls, input logic [CNT_W-1:0] mag);
    if (cls == CLS_OK && mag != '0) return 2'd1;
    if (cls == CLS_WARN)            return 2'd2;
    return 2'd0;
  endfunction

  // returns {overflow, next trim}
  function automatic logic [TRIM_W:0] crt_trim_next(input logic [TRIM_W-1:0] cur,
                                                     input logic [1:0] step,
                                                     input logic go_up);
    logic [TRIM_W+1:0] a;
    logic [TRIM_W+1:0] s;
    a = {2'b00, cur};
    s = {{TRIM_W{1'b0}}, step};
    if (go_up) begin
      if (a + s > {2'b00, TRIM_MAX}) return {1'b1, TRIM_MAX};
      return {1'b0, cur + TRIM_W'(step)};
    end
    if (s > a) return {1'b1, {TRIM_W{1'b0}}};
    return {1'b0, cur - TRIM_W'(step)};
  endfunction
endpackage

// File: rtl/crt_sync_front.sv
module crt_sync_front
  import crt_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  input  logic [DIV_W-1:0] div_code,
  input  logic             sw_sync,
  output logic             ext_evt_o,
  output logic             sync_evt_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             raw;
  logic             prev_q;
  logic             edge_det;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    raw      = (int'(sel) < NSRC) ? src_i[sel] : src_i[0];
    edge_det = pol ? (prev_q & ~raw) : (raw & ~prev_q);
    mask     = ~({PRE_W{1'b1}} << div_code);
    ext_evt_o  = en && edge_det && (pre_q == mask);
    sync_evt_o = ext_evt_o || (en && sw_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      prev_q <= raw;
      if (!en)            pre_q <= '0;
      else if (edge_det)  pre_q <= (pre_q == mask) ? '0 : pre_q + 1'b1;
    end
  end

  p_prescale_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt_o |=> (pre_q == '0));
  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_q == '0));
endmodule

// File: rtl/crt_err_counter.sv
module crt_err_counter
  import crt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_evt,
  input  logic [CNT_W-1:0] reload,
  input  logic [LIM_W-1:0] limit,
  output logic [CNT_W-1:0] cap_o,
  output logic             dir_o,
  output logic             judge_vld_o,
  output crt_cls_e         judge_cls_o,
  output logic [CNT_W-1:0] judge_mag_o,
  output logic             judge_dir_o,
  output logic             esync_o,
  output logic             miss_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             stop_q;
  logic             at_zero;

  always_comb begin
    at_zero     = !up_q && (cnt_q == '0);
    esync_o     = en && at_zero;
    judge_vld_o = en && sync_evt && !stop_q;
    judge_mag_o = cnt_q;
    judge_dir_o = up_q;
    judge_cls_o = crt_classify(cnt_q, limit);
    miss_o      = en && !sync_evt && up_q && !stop_q && (cnt_q > crt_lim3(limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD_RST;
      up_q   <= 1'b0;
      stop_q <= 1'b0;
      cap_o  <= '0;
      dir_o  <= 1'b0;
    end else if (!en) begin
      cnt_q  <= reload;
      up_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (sync_evt) begin
      cap_o  <= cnt_q;
      dir_o  <= up_q;
      cnt_q  <= reload;
      up_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (stop_q) begin
      cnt_q  <= cnt_q;
    end else if (miss_o) begin
      stop_q <= 1'b1;
    end else if (at_zero) begin
      up_q   <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (up_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  p_hold_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_q && !sync_evt) |=> $stable(cnt_q));
  p_turn_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (esync_o && !sync_evt) |=> (up_q && cnt_q == CNT_W'(1)));
  p_sync_reloads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sync_evt) |=> (!up_q && !stop_q));
endmodule

// File: rtl/crt_trim_ctrl.sv
module crt_trim_ctrl
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              sw_wr,
  input  logic [TRIM_W-1:0] sw_trim,
  input  logic              judge_vld,
  input  crt_cls_e          judge_cls,
  input  logic [CNT_W-1:0]  judge_mag,
  input  logic              judge_dir,
  output logic [TRIM_W-1:0] trim_o,
  output logic              ovf_o
);
  logic [1:0]        step;
  logic [TRIM_W:0]   nxt;
  logic              adj;

  always_comb begin
    step  = crt_step(judge_cls, judge_mag);
    nxt   = crt_trim_next(trim_o, step, judge_dir);
    adj   = auto_en && judge_vld && (step != 2'd0);
    ovf_o = adj && nxt[TRIM_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 trim_o <= TRIM_RST;
    else if (!auto_en && sw_wr) trim_o <= sw_trim;
    else if (adj)               trim_o <= nxt[TRIM_W-1:0];
  end

  p_trim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !judge_vld) |=> $stable(trim_o));
  p_trim_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && judge_vld) |=>
      ((int'(trim_o) - int'($past(trim_o)) <= 2) && (int'($past(trim_o)) - int'(trim_o) <= 2)));
endmodule

// File: rtl/crt_trimmer.sv
module crt_trimmer
  import crt_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NSRC-1:0]   sync_in,
  output logic [TRIM_W-1:0] trim_o,
  output logic              irq_o
);
  logic [3:0]       ie_q;
  logic             cnt_en_q, auto_q;
  logic [CNT_W-1:0] reload_q;
  logic [LIM_W-1:0] limit_q;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] src_q;
  logic             pol_q;
  logic             ok_q, warn_q, esync_q, serr_q, miss_q, ovf_q;

  logic             ctrl_wr, cfg_wr, clr_wr, sw_sync;
  logic             ext_evt, sync_evt;
  logic [CNT_W-1:0] cap, judge_mag;
  logic             dir, judge_vld, judge_dir, esync_evt, miss_evt, ovf_evt;
  crt_cls_e         judge_cls;
  logic             err_any;
  logic [31:0]      ctrl_rd, cfg_rd, stat_rd;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    cfg_wr  = wr_en && (wr_addr == A_CFG) && !cnt_en_q;
    clr_wr  = wr_en && (wr_addr == A_CLR);
    sw_sync = ctrl_wr && wr_data[B_SWSYNC];
  end

  crt_sync_front #(.NSRC(NSRC)) u_front (
    .clk(clk), .rst_n(rst_n), .en(cnt_en_q), .src_i(sync_in), .sel(src_q),
    .pol(pol_q), .div_code(div_q), .sw_sync(sw_sync),
    .ext_evt_o(ext_evt), .sync_evt_o(sync_evt));

  crt_err_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en_q), .sync_evt(sync_evt),
    .reload(reload_q), .limit(limit_q), .cap_o(cap), .dir_o(dir),
    .judge_vld_o(judge_vld), .judge_cls_o(judge_cls), .judge_mag_o(judge_mag),
    .judge_dir_o(judge_dir), .esync_o(esync_evt), .miss_o(miss_evt));

  crt_trim_ctrl u_trim (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_q), .sw_wr(ctrl_wr),
    .sw_trim(wr_data[B_TRIM +: TRIM_W]), .judge_vld(judge_vld),
    .judge_cls(judge_cls), .judge_mag(judge_mag), .judge_dir(judge_dir),
    .trim_o(trim_o), .ovf_o(ovf_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      cnt_en_q <= 1'b0;
      auto_q   <= 1'b0;
      reload_q <= RELOAD_RST;
      limit_q  <= LIMIT_RST;
      div_q    <= '0;
      src_q    <= SRC_RST;
      pol_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ie_q     <= wr_data[3:0];
        cnt_en_q <= wr_data[B_EN];
        auto_q   <= wr_data[B_AUTO];
      end
      if (cfg_wr) begin
        reload_q <= wr_data[CNT_W-1:0];
        limit_q  <= wr_data[B_LIM +: LIM_W];
        div_q    <= wr_data[B_DIV +: DIV_W];
        src_q    <= wr_data[B_SRC +: SEL_W];
        pol_q    <= wr_data[B_POL];
      end
    end
  end

  // sticky flags: a set on the same edge wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ok_q, warn_q, esync_q, serr_q, miss_q, ovf_q} <= '0;
    end else begin
      ok_q    <= (ok_q    && !(clr_wr && wr_data[0])) || (judge_vld && judge_cls == CLS_OK);
      warn_q  <= (warn_q  && !(clr_wr && wr_data[1])) || (judge_vld && judge_cls == CLS_WARN);
      esync_q <= (esync_q && !(clr_wr && wr_data[3])) || esync_evt;
      serr_q  <= (serr_q  && !(clr_wr && wr_data[2])) || (judge_vld && judge_cls == CLS_ERR);
      miss_q  <= (miss_q  && !(clr_wr && wr_data[2])) || miss_evt;
      ovf_q   <= (ovf_q   && !(clr_wr && wr_data[2])) || ovf_evt;
    end
  end

  always_comb begin
    err_any = serr_q | miss_q | ovf_q;
    irq_o   = (ok_q & ie_q[0]) | (warn_q & ie_q[1]) | (err_any & ie_q[2]) | (esync_q & ie_q[3]);
    ctrl_rd = {17'b0, trim_o, 1'b0, auto_q, cnt_en_q, 1'b0, ie_q};
    cfg_rd  = {pol_q, 1'b0, src_q, 1'b0, div_q, limit_q, reload_q};
    stat_rd = {cap, dir, 4'b0, ovf_q, miss_q, serr_q, 4'b0, esync_q, err_any, warn_q, ok_q};
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_rd;
      A_CFG:   rd_data = cfg_rd;
      A_STAT:  rd_data = stat_rd;
      default: rd_data = '0;
    endcase
  end

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_q |=> $stable(cfg_rd));
  p_ok_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && !(clr_wr && wr_data[0])) |=> ok_q);
  p_irq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ok_q || warn_q || err_any || esync_q));
  p_ext_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |-> cnt_en_q);
endmodule

// File: tb/crt_trimmer_tb_top.sv
module crt_trimmer_tb_top;
  localparam int WD_CYCLES = 100000;
  localparam logic [31:0] EN = 32'h20, AUTO = 32'h40, SW = 32'h80, IE_ALL = 32'hF;

  typedef struct packed {
    logic [15:0] rel;
    logic [7:0]  lim;
    logic [15:0] per;
    logic [1:0]  cls;   // 0 ok, 1 warn, 2 sync error
    logic [6:0]  trim;  // expected trim after start at 64
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'd99,  8'd34, 16'd100, 2'd0, 7'd64},
    '{16'd99,  8'd34, 16'd95,  2'd0, 7'd63},
    '{16'd99,  8'd34, 16'd110, 2'd0, 7'd65},
    '{16'd99,  8'd34, 16'd140, 2'd1, 7'd66},
    '{16'd99,  8'd34, 16'd60,  2'd1, 7'd62},
    '{16'd99,  8'd34, 16'd134, 2'd1, 7'd66},
    '{16'd99,  8'd34, 16'd133, 2'd0, 7'd65},
    '{16'd99,  8'd34, 16'd202, 2'd2, 7'd64},
    '{16'd199, 8'd20, 16'd140, 2'd2, 7'd64},
    '{16'd199, 8'd20, 16'd259, 2'd1, 7'd66}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [2:0]  sync_in;
  logic [6:0]  trim_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crt_trimmer #(.NSRC(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sync_in(sync_in), .trim_o(trim_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [31:0] mk_cfg(input int r, input int l, input int dv, input int s, input int p);
    return (32'(p) << 31) | (32'(s) << 28) | (32'(dv) << 24) | (32'(l) << 16) | 32'(r);
  endfunction

  function automatic logic [31:0] mk_stat(input int cls, input int cap, input bit dir,
                                          input bit es, input bit ovf);
    logic [31:0] v;
    v = (32'(cap) << 16) | (32'(dir) << 15);
    if (cls == 0) v |= 32'h1;
    if (cls == 1) v |= 32'h2;
    if (cls == 2) v |= 32'h104;
    if (ovf) v |= 32'h404;
    if (es) v |= 32'h8;
    return v;
  endfunction

  // start counting from trim t0, then software sync p clocks after the enabling edge
  task automatic run_case(input int r, input int l, input int p, input int t0,
                          input bit au, input logic [3:0] ie);
    logic [31:0] base;
    base = EN | (au ? AUTO : 32'h0) | 32'(ie) | (32'(t0) << 8);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'(t0) << 8);
    wr(2'd1, mk_cfg(r, l, 0, 2, 0));
    wr(2'd3, 32'hF);
    wr(2'd0, base);
    repeat (p - 1) @(negedge clk);
    wr(2'd0, base | SW);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; sync_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 32'h0000_4000);
    rd(2'd1, d); check("R1 cfg", d, 32'h2022_BB7F);
    rd(2'd2, d); check("R1 stat", d, 32'h0);
    check("R1 trim", 32'(trim_o), 32'd64);
    check("R1 irq", 32'(irq_o), 32'd0);

    // R2 R3 R4 R6 R11 R13: table of software-synced measurements
    for (int i = 0; i < 10; i++) begin
      int r, p, cap;
      bit dir, es;
      r = int'(VECS[i].rel); p = int'(VECS[i].per);
      dir = (p > r + 1);
      es  = (p >= r + 1);
      cap = dir ? p - r - 1 : r + 1 - p;
      run_case(r, int'(VECS[i].lim), p, 64, 1'b1, 4'hF);
      rd(2'd2, d);
      check($sformatf("R2 R3 R4 stat vec%0d", i), d, mk_stat(int'(VECS[i].cls), cap, dir, es, 1'b0));
      check($sformatf("R6 trim vec%0d", i), 32'(trim_o), 32'(VECS[i].trim));
      check($sformatf("R13 irq vec%0d", i), 32'(irq_o), 32'd1);
    end

    // R9 config locked while counting, R8 trim locked in auto mode
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d); check("R9 cfg locked", d, mk_cfg(199, 20, 0, 2, 0));
    wr(2'd0, EN | AUTO | IE_ALL | (32'd5 << 8));
    check("R8 auto ignores trim write", 32'(trim_o), 32'd66);
    wr(2'd0, 32'h0);
    check("R8 trim write while leaving auto", 32'(trim_o), 32'd66);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d); check("R9 cfg open", d, 32'h1234_5678);
    wr(2'd0, 32'd5 << 8);
    check("R8 manual trim write", 32'(trim_o), 32'd5);

    // R5 missed sync, recovery, R12 clears
    wr(2'd0, 32'd64 << 8);
    wr(2'd1, mk_cfg(19, 5, 0, 2, 0));
    wr(2'd3, 32'hF);
    wr(2'd0, EN | AUTO | IE_ALL | (32'd64 << 8));
    repeat (60) @(negedge clk);
    rd(2'd2, d); check("R5 miss flags", d & 32'h0000_7FFF, 32'h0000_020C);
    check("R5 trim untouched", 32'(trim_o), 32'd64);
    wr(2'd0, EN | AUTO | IE_ALL | SW);
    rd(2'd2, d); check("R5 recovery not graded", d, 32'h0010_820C);
    repeat (19) @(negedge clk);
    wr(2'd0, EN | AUTO | IE_ALL | SW);
    rd(2'd2, d); check("R5 R12 resumed, miss sticky", d, 32'h0000_020D);
    wr(2'd3, 32'h4);
    rd(2'd2, d); check("R12 error group clear", d, 32'h0000_0009);
    wr(2'd3, 32'h1);
    rd(2'd2, d); check("R12 ok clear", d, 32'h0000_0008);

    // R7 saturation at both rails
    run_case(99, 34, 110, 127, 1'b1, 4'hF);
    rd(2'd2, d); check("R7 top rail stat", d, 32'h000A_840D);
    check("R7 top rail trim", 32'(trim_o), 32'd127);
    run_case(99, 34, 60, 0, 1'b1, 4'hF);
    rd(2'd2, d); check("R7 bottom rail stat", d, 32'h0028_0406);
    check("R7 bottom rail trim", 32'(trim_o), 32'd0);
    run_case(99, 34, 140, 126, 1'b1, 4'hF);
    rd(2'd2, d); check("R7 step past top stat", d, 32'h0028_840E);
    check("R7 step past top trim", 32'(trim_o), 32'd127);

    // R6 R11 manual mode, R13 masked interrupt
    run_case(99, 34, 95, 30, 1'b0, 4'hF);
    rd(2'd2, d); check("R11 manual sync stat", d, 32'h0005_0001);
    check("R6 manual trim unchanged", 32'(trim_o), 32'd30);
    run_case(99, 34, 95, 64, 1'b1, 4'h2);
    check("R13 irq masked", 32'(irq_o), 32'd0);

    // R10 falling edges on source 0 through divide by 4; source 2 toggles too
    wr(2'd0, 32'h0);
    wr(2'd0, 32'd64 << 8);
    wr(2'd1, mk_cfg(19, 5, 2, 0, 1));
    wr(2'd3, 32'hF);
    sync_in = 3'b101;
    @(negedge clk);
    wr(2'd0, EN | AUTO | IE_ALL | (32'd64 << 8));
    for (int k = 0; k < 4; k++) begin
      repeat ((k == 0) ? 2 : 3) @(negedge clk);
      sync_in[0] = 1'b1;
      if (k == 0) sync_in[2] = 1'b0;
      repeat (2) @(negedge clk);
      sync_in[0] = 1'b0;
    end
    @(negedge clk);
    rd(2'd2, d); check("R10 divided falling edges", d, 32'h0000_0009);

    // R10 rising edge on source 1, source 0 pulse ignored
    wr(2'd0, 32'h0);
    sync_in = 3'b000;
    wr(2'd1, mk_cfg(9, 5, 0, 1, 0));
    wr(2'd3, 32'hF);
    wr(2'd0, EN | AUTO | IE_ALL | (32'd64 << 8));
    repeat (4) @(negedge clk);
    sync_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    sync_in[1] = 1'b1;
    @(negedge clk);
    rd(2'd2, d); check("R10 rising edge on source 1", d, 32'h0000_0009);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule